// File: doc/BRIEF.md
# SPI Master Burst Sequencer

This block is the shifting core of an SPI master. Software loads a burst length, a transmit length and a set of mode bits into three small registers. It then sets a go bit, and the block clocks out the whole burst without further help. While the transmit length lasts, each byte is taken from an external transmit queue. The remaining bytes of the burst carry zero. Every byte received on the input line is handed to an external receive queue, unless the mode bits ask for received data to be thrown away, as in a send-only transfer.

All four clock polarity and phase combinations are supported, and each byte can be sent either bit order. One of up to four chip-select lines is asserted for the duration of the burst, and the active level of those lines is programmable. Software can also take the selected line over and hold it at a fixed level. The go bit reads back as 1 while the burst runs. It drops in the same cycle that a one-cycle completion pulse appears.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset the control word reads 0, SCK is 0, all chip-select lines are 0, and the completion, pop and push strobes are low.
- R2: Writing the control register (select 0) with bit 31 set while idle runs exactly burst-count bytes of 8 SCK cycles each. It produces one completion pulse of one cycle. Bit 31 reads 1 during the run and 0 from the cycle of the pulse onward.
- R3: The first min(burst, transmit count) bytes each pop one byte from the transmit queue and send it. The later bytes send 0x00 and do not pop.
- R4: Bit 1 sets the SCK idle level. With bit 0 clear, MOSI is valid before the leading edge and MISO is sampled on the leading edge. With bit 0 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: With bit 12 set, each byte is sent and received least-significant bit first. With bit 12 clear, it is most-significant bit first.
- R6: Each completed byte is pushed to the receive queue with the value received on MISO, unless bit 8 is set, in which case nothing is pushed.
- R7: Bits 5:4 pick the chip-select line. Bit 2 set makes the lines idle high and assert low; bit 2 clear makes them idle low and assert high. Only the picked line is ever asserted, and only while bytes are pending.
- R8: With bit 6 set, the picked line is driven to the value of bit 7 at all times, whether or not a burst runs.
- R9: A burst count of 0 gives the completion pulse in the cycle after the go write, with no SCK edge and no chip-select assertion.
- R10: While a byte still due from the transmit queue is unavailable, the engine waits with SCK at its idle level and the chip select held. It resumes when data arrives.
- R11: Register writes (select 0 for control, 1 for burst count, 2 for transmit count) arriving while a burst runs are ignored.
- R12: A go write made in the very cycle the completion pulse is visible is accepted and starts the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 burst count, 2 transmit count |
| reg_wdata | input | 32 | Write data |
| ctrl_rd | output | 32 | Current control word including the go bit |
| tx_valid | input | 1 | Transmit queue has a byte |
| tx_data | input | 8 | Transmit queue head byte |
| tx_pop | output | 1 | Takes the head byte |
| rx_push | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| xfer_done | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
The completion pulse and the acceptance of a fresh go write can share one cycle. The block returns to idle on the same edge that raises the pulse, so a write in that cycle is taken. The bench waits for the pulse, issues the go write in that same cycle, and then expects the go bit to read 1 again. It also expects a second pulse and twice the SCK edges of a single one-byte burst. A second coincidence exists between a write during a run and the run itself: the bench writes new mode and length values mid-burst and expects both that burst and a following one to keep the old settings.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_NEXT = 2'd1, SQ_SHIFT = 2'd2} seq_state_t;

  localparam int CB_CPHA = 0;
  localparam int CB_CPOL = 1;
  localparam int CB_ALO  = 2;
  localparam int CB_SEL  = 4;
  localparam int CB_MAN  = 6;
  localparam int CB_MLVL = 7;
  localparam int CB_DISC = 8;
  localparam int CB_LSB  = 12;
  localparam int CB_GO   = 31;

  localparam logic [31:0] CTRL_MASK = 32'h8000_11F7;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] din,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          act,
  output logic          done,
  output logic [DW-1:0] dout
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic          act_q, half_q, done_q, sck_q, mosi_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q, rx_q;

  function automatic logic head(input logic [DW-1:0] b, input logic lf);
    return lf ? b[0] : b[DW-1];
  endfunction

  function automatic logic [DW-1:0] drop(input logic [DW-1:0] b, input logic lf);
    return lf ? {1'b0, b[DW-1:1]} : {b[DW-2:0], 1'b0};
  endfunction

  function automatic logic [DW-1:0] absorb(input logic [DW-1:0] r, input logic bi, input logic lf);
    return lf ? {bi, r[DW-1:1]} : {r[DW-2:0], bi};
  endfunction

  wire lead_edge  = act_q && !half_q;
  wire trail_edge = act_q && half_q;
  wire samp_now   = cpha ? trail_edge : lead_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (go) begin
          act_q  <= 1'b1;
          half_q <= 1'b0;
          bit_q  <= '0;
          sh_q   <= din;
          sck_q  <= cpol;
          if (!cpha) mosi_q <= head(din, lsb);
        end
      end else if (!half_q) begin
        sck_q  <= ~cpol;
        half_q <= 1'b1;
        if (cpha) mosi_q <= head(sh_q, lsb);
      end else begin
        sck_q  <= cpol;
        half_q <= 1'b0;
        sh_q   <= drop(sh_q, lsb);
        if (!cpha && bit_q != LAST) mosi_q <= head(drop(sh_q, lsb), lsb);
        bit_q  <= bit_q + BW'(1);
        if (bit_q == LAST) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (samp_now) rx_q <= absorb(rx_q, miso, lsb);
    end
  end

  assign sck  = act_q ? sck_q : cpol;
  assign mosi = mosi_q;
  assign act  = act_q;
  assign done = done_q;
  assign dout = rx_q;

  assert_half_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lead_edge |=> (act_q && half_q));
  assert_byte_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !$past(done_q) && !act_q);
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NCS = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SW-1:0]  sel,
  input  logic           act_low,
  input  logic           man_en,
  input  logic           man_lvl,
  input  logic           engaged,
  output logic [NCS-1:0] cs
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    always_comb begin
      if (SW'(i) != sel)  cs[i] = act_low;
      else if (man_en)    cs[i] = man_lvl;
      else                cs[i] = engaged ? ~act_low : act_low;
    end
  end

  assert_one_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !man_en |-> $onehot0(cs ^ {NCS{act_low}}));
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int NCS   = 4,
  parameter int DW    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_sel,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    ctrl_rd,
  input  logic           tx_valid,
  input  logic [DW-1:0]  tx_data,
  output logic           tx_pop,
  output logic           rx_push,
  output logic [DW-1:0]  rx_data,
  output logic           xfer_done,
  output logic           sck_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_o
);
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1;

  seq_state_t       st_q;
  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] burst_q, txcnt_q, left_q, txleft_q;
  logic             done_q;
  logic             eng_act, eng_done;

  wire idle      = (st_q == SQ_IDLE);
  wire wr_ok     = reg_we && idle;
  wire kick      = wr_ok && (reg_sel == 2'd0) && reg_wdata[CB_GO];
  wire need_byte = (st_q == SQ_NEXT) && (left_q != '0);
  wire from_fifo = need_byte && (txleft_q != '0);
  wire starve    = from_fifo && !tx_valid;
  wire go_byte   = need_byte && !starve;
  wire finish    = (st_q == SQ_NEXT) && (left_q == '0);
  wire engaged   = (st_q == SQ_SHIFT) || need_byte;
  wire [DW-1:0] out_byte = from_fifo ? tx_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      ctrl_q   <= '0;
      burst_q  <= '0;
      txcnt_q  <= '0;
      left_q   <= '0;
      txleft_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (wr_ok) begin
            case (reg_sel)
              2'd0: begin
                ctrl_q <= reg_wdata & CTRL_MASK;
                if (kick) begin
                  left_q   <= burst_q;
                  txleft_q <= txcnt_q;
                  st_q     <= SQ_NEXT;
                end
              end
              2'd1:    burst_q <= reg_wdata[CNT_W-1:0];
              2'd2:    txcnt_q <= reg_wdata[CNT_W-1:0];
              default: ;
            endcase
          end
        end
        SQ_NEXT: begin
          if (finish) begin
            done_q        <= 1'b1;
            ctrl_q[CB_GO] <= 1'b0;
            st_q          <= SQ_IDLE;
          end else if (go_byte) begin
            left_q <= left_q - CNT_W'(1);
            if (from_fifo) txleft_q <= txleft_q - CNT_W'(1);
            st_q <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: if (eng_done) st_q <= SQ_NEXT;
        default:  st_q <= SQ_IDLE;
      endcase
    end
  end

  spi_byte_shifter #(.DW(DW)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go_byte),
    .din  (out_byte),
    .cpol (ctrl_q[CB_CPOL]),
    .cpha (ctrl_q[CB_CPHA]),
    .lsb  (ctrl_q[CB_LSB]),
    .miso (miso_i),
    .sck  (sck_o),
    .mosi (mosi_o),
    .act  (eng_act),
    .done (eng_done),
    .dout (rx_data)
  );

  spi_cs_drive #(.NCS(NCS)) u_cs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (ctrl_q[CB_SEL +: SW]),
    .act_low(ctrl_q[CB_ALO]),
    .man_en (ctrl_q[CB_MAN]),
    .man_lvl(ctrl_q[CB_MLVL]),
    .engaged(engaged),
    .cs     (cs_o)
  );

  assign tx_pop    = from_fifo && tx_valid;
  assign rx_push   = eng_done && !ctrl_q[CB_DISC];
  assign xfer_done = done_q;
  assign ctrl_rd   = ctrl_q;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  assert_pop_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop && eng_act);
  assert_push_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (st_q == SQ_SHIFT) && !eng_act);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> $stable(sck_o) && !eng_act);
  assert_busy_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !idle) |=> $stable(burst_q) && $stable(txcnt_q));
endmodule

// File: tb/sim_spi_xfer_seq.sv
module sim_spi_xfer_seq;
  localparam logic [31:0] K_CPHA = 32'h1,   K_CPOL = 32'h2,   K_ALO = 32'h4;
  localparam logic [31:0] K_MAN  = 32'h40,  K_MLVL = 32'h80,  K_DISC = 32'h100;
  localparam logic [31:0] K_LSB  = 32'h1000, K_GO  = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, ctrl_rd;
  logic tx_valid, tx_pop, rx_push, xfer_done, sck_o, mosi_o, miso_i;
  logic [7:0] tx_data, rx_data;
  logic [3:0] cs_o;

  int errors = 0, checks = 0;
  logic [7:0] tx_mem [16];
  logic [7:0] sl_tx [16];
  logic [7:0] mo_got [16];
  logic [7:0] rx_got [16];
  int tx_rd = 0, tx_n = 0, n_pop = 0, n_done = 0, rx_n = 0;
  int k_sh = 0, k_cap = 0, n_lead = 0;
  logic tx_en = 1'b0, sl_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;

  always #2.5 clk = ~clk;

  spi_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rd(ctrl_rd), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .xfer_done(xfer_done), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o)
  );

  assign tx_valid = tx_en && (tx_rd < tx_n);
  assign tx_data  = tx_mem[tx_rd % 16];
  always_comb miso_i = sl_tx[(k_sh / 8) % 16][m_lsb ? (k_sh % 8) : (7 - (k_sh % 8))];

  always @(posedge clk) begin
    if (tx_pop) begin tx_rd <= tx_rd + 1; n_pop = n_pop + 1; end
    if (xfer_done) n_done = n_done + 1;
    if (rx_push) begin rx_got[rx_n % 16] = rx_data; rx_n = rx_n + 1; end
  end

  task automatic cap_bit();
    int j = k_cap % 8;
    mo_got[(k_cap / 8) % 16][m_lsb ? j : 7 - j] = mosi_o;
    k_cap = k_cap + 1;
  endtask

  always @(sck_o) if (sl_en) begin
    if (sck_o !== m_cpol) begin
      n_lead = n_lead + 1;
      if (!m_cpha) cap_bit();
    end else begin
      if (m_cpha) cap_bit();
      k_sh = k_sh + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_counts();
    sl_en = 1'b0; k_sh = 0; k_cap = 0; n_lead = 0; n_pop = 0; n_done = 0; rx_n = 0; tx_rd = 0;
    for (int i = 0; i < 16; i++) begin mo_got[i] = 8'h00; rx_got[i] = 8'h00; end
  endtask

  task automatic prep(input logic [31:0] cw, input int ntx);
    clear_counts();
    m_cpol = cw[1]; m_cpha = cw[0]; m_lsb = cw[12];
    for (int i = 0; i < 16; i++) begin
      tx_mem[i] = 8'hC3 ^ 8'(i * 37);
      sl_tx[i]  = 8'h5A + 8'(i * 29);
    end
    tx_n = ntx; tx_en = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!xfer_done && t < 3000) begin @(negedge clk); t++; end
    chk(xfer_done == 1'b1, req, "completion pulse seen", xfer_done, 1);
  endtask

  task automatic run_burst(input string req, input logic [31:0] cw, input int nb, input int ntx);
    int npop = (nb < ntx) ? nb : ntx;
    prep(cw, ntx);
    wr(2'd1, 32'(nb)); wr(2'd2, 32'(ntx)); wr(2'd0, cw);
    sl_en = 1'b1;
    wr(2'd0, cw | K_GO);
    chk(ctrl_rd[31] == 1'b1, "R2", "go bit while running", ctrl_rd[31], 1);
    wait_done(req);
    repeat (2) @(negedge clk);
    chk(n_done == 1, "R2", "completion count", n_done, 1);
    chk(ctrl_rd[31] == 1'b0, "R2", "go bit after end", ctrl_rd[31], 0);
    chk(n_lead == 8 * nb, "R2", "leading SCK edges", n_lead, 8 * nb);
    chk(n_pop == npop, "R3", "queue pops", n_pop, npop);
    chk(sck_o == cw[1], "R4", "SCK idle level", sck_o, cw[1]);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] e = (i < npop) ? tx_mem[i] : 8'h00;
      chk(mo_got[i] == e, req, "MOSI byte", mo_got[i], e);
    end
    if (cw[8]) chk(rx_n == 0, "R6", "pushes with discard", rx_n, 0);
    else begin
      chk(rx_n == nb, "R6", "push count", rx_n, nb);
      for (int i = 0; i < nb; i++)
        chk(rx_got[i] == sl_tx[i], req, "received byte", rx_got[i], sl_tx[i]);
    end
  endtask

  task automatic t_reset();
    chk(ctrl_rd == 32'h0, "R1", "control after reset", ctrl_rd, 0);
    chk(sck_o == 1'b0 && cs_o == 4'h0, "R1", "SCK and CS after reset", {sck_o, cs_o}, 0);
    chk(!xfer_done && !tx_pop && !rx_push, "R1", "strobes after reset", {xfer_done, tx_pop, rx_push}, 0);
  endtask

  task automatic t_cs_select();
    logic [31:0] cw = K_ALO | (32'd2 << 4);
    prep(cw, 0);
    wr(2'd1, 32'd1); wr(2'd2, 32'd0); wr(2'd0, cw);
    chk(cs_o == 4'hF, "R7", "idle lines active-low", cs_o, 4'hF);
    wr(2'd0, cw | K_GO);
    repeat (3) @(negedge clk);
    chk(cs_o == 4'b1011, "R7", "line 2 asserted", cs_o, 4'b1011);
    wait_done("R7");
    @(negedge clk);
    chk(cs_o == 4'hF, "R7", "line released", cs_o, 4'hF);
  endtask

  task automatic t_manual();
    logic [31:0] cw = K_MAN | (32'd1 << 4);
    prep(cw, 0);
    wr(2'd0, cw | K_MLVL);
    chk(cs_o == 4'b0010, "R8", "manual level high", cs_o, 4'b0010);
    wr(2'd0, cw);
    chk(cs_o == 4'b0000, "R8", "manual level low", cs_o, 4'b0000);
    wr(2'd1, 32'd1); wr(2'd2, 32'd0);
    wr(2'd0, cw | K_GO);
    repeat (4) @(negedge clk);
    chk(cs_o == 4'b0000, "R8", "manual level held during burst", cs_o, 4'b0000);
    wait_done("R8");
    wr(2'd0, 32'h0);
  endtask

  task automatic t_zero();
    prep(32'h0, 0);
    wr(2'd1, 32'd0); wr(2'd2, 32'd0);
    sl_en = 1'b1;
    wr(2'd0, K_GO);
    chk(ctrl_rd[31] == 1'b1 && !xfer_done, "R9", "pending after go write", {ctrl_rd[31], xfer_done}, 2);
    chk(cs_o == 4'h0, "R9", "CS not asserted", cs_o, 0);
    @(negedge clk);
    chk(xfer_done == 1'b1 && ctrl_rd[31] == 1'b0, "R9", "immediate completion", {xfer_done, ctrl_rd[31]}, 2);
    chk(n_lead == 0 && cs_o == 4'h0, "R9", "no SCK edge, no CS", n_lead, 0);
  endtask

  task automatic t_stall();
    prep(K_CPOL, 2);
    tx_en = 1'b0;
    wr(2'd1, 32'd2); wr(2'd2, 32'd2); wr(2'd0, K_CPOL);
    sl_en = 1'b1;
    wr(2'd0, K_CPOL | K_GO);
    repeat (30) @(negedge clk);
    chk(n_lead == 0 && sck_o == 1'b1, "R10", "SCK idle while starved", {n_lead[7:0], sck_o}, 1);
    chk(cs_o == 4'b0001 && ctrl_rd[31], "R10", "CS held while starved", cs_o, 4'b0001);
    tx_en = 1'b1;
    wait_done("R10");
    repeat (2) @(negedge clk);
    chk(n_pop == 2 && n_lead == 16, "R10", "resumed burst", n_lead, 16);
    chk(mo_got[0] == tx_mem[0] && mo_got[1] == tx_mem[1], "R10", "bytes after stall", mo_got[1], tx_mem[1]);
  endtask

  task automatic t_busy_write();
    prep(32'h0, 0);
    wr(2'd1, 32'd2); wr(2'd2, 32'd0); wr(2'd0, 32'h0);
    sl_en = 1'b1;
    wr(2'd0, K_GO);
    repeat (4) @(negedge clk);
    wr(2'd0, K_CPOL | K_LSB);
    wr(2'd1, 32'd5);
    wait_done("R11");
    @(negedge clk);
    chk(ctrl_rd == 32'h0, "R11", "control unchanged by busy write", ctrl_rd, 0);
    chk(n_lead == 16, "R11", "burst length kept", n_lead, 16);
    clear_counts(); sl_en = 1'b1;
    wr(2'd0, K_GO);
    wait_done("R11");
    @(negedge clk);
    chk(n_lead == 16, "R11", "count register unchanged", n_lead, 16);
  endtask

  task automatic t_back_to_back();
    prep(32'h0, 0);
    wr(2'd1, 32'd1); wr(2'd2, 32'd0);
    sl_en = 1'b1;
    wr(2'd0, K_GO);
    wait_done("R12");
    chk(ctrl_rd[31] == 1'b0, "R12", "go bit low with pulse", ctrl_rd[31], 0);
    wr(2'd0, K_GO);
    chk(ctrl_rd[31] == 1'b1, "R12", "go write in pulse cycle accepted", ctrl_rd[31], 1);
    wait_done("R12");
    repeat (2) @(negedge clk);
    chk(n_done == 2 && n_lead == 16, "R12", "two bursts ran", n_lead, 16);
  endtask

  initial begin
    #(150000 * 5);
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_burst("R3", 32'h0, 4, 4);
    run_burst("R4", K_CPOL | K_CPHA, 3, 1);
    run_burst("R5", K_CPHA | K_LSB, 2, 2);
    run_burst("R6", K_CPOL | K_DISC | K_LSB, 3, 3);
    t_cs_select();
    t_manual();
    t_zero();
    t_stall();
    t_busy_write();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule